// File: doc/BRIEF.md
# Memory BIST Pattern Engine

The engine fills a programmable, ascending address window of a memory with a test pattern and can read the window back and compare every stored bit. Each stored word is the full width of the array, data lanes and check-bit lanes together. The engine computes no check bits: the pattern is written raw across the whole word, and the read-back compare is an exact bitwise equality over the whole word.

Three pattern sources are offered. The first is a complementary nibble pair that alternates from one address to the next. The second is a linear feedback shift register stepped once per word. The third is a bank of software-loaded data registers, which can be rotated by one bit after every word. Software programs the window, the seed, the bank and a control word through a simple register write port. A go bit in the control word starts a run. The engine then issues requests as fast as the memory port grants them, and it reports busy, done, a sticky fail flag, the first failing address and that word's mismatch mask.

Top module: `mbist_engine`

## Requirements
- R1: A control write with bit 15 set starts a run while idle. Requests cover addresses from the low bound (register 1) up to the high bound (register 2) in ascending order, and a new request follows every grant with no idle cycle. With the grant held high, a write-only run of N words finishes within N+4 cycles of the go write.
- R2: Source code 0 (control bits [3:2]) selects the fixed pattern, whose 3-bit code is in control bits [6:4]. Code bits [2:1] pick the pair: 0 gives 0/F, 1 gives A/5, 2 gives 3/C and 3 gives 6/9. Bit 0 set makes the second member come first. The member alternates at each address of the window, and the nibble is repeated over all 64 bits of the word.
- R3: Source code 1 selects the shift register. It is loaded with the 16-bit seed (register 3) repeated four times. It supplies one word per address and then steps as next = {s[62:0], s[63]^s[62]^s[60]^s[59]}.
- R4: Source code 2 or 3 writes the data bank as one word. Register 4 holds bits [15:0], register 5 bits [31:16], register 6 bits [47:32] and register 7 bits [63:48].
- R5: With control bit 7 set in bank mode, each word after the first is the previous word rotated left by one bit.
- R6: A bank of all zeros in bank mode fills the window with all-zero words, check lanes included.
- R7: In a read pass, any difference in any of the 64 bits between read data and the expected pattern sets the fail flag. The expected pattern restarts from its initial state (the same seed or bank) for the read pass.
- R8: The address and the XOR mismatch mask of the first failing word are latched, and later mismatches in the same run leave them unchanged.
- R9: The mode field (control bits [1:0]) selects the passes. 0 is write only and issues no reads. 1 is verify only and issues no writes. 2 or 3 writes the window and then verifies it.
- R10: Done rises after the final response of the last pass and stays high while the engine is idle. Done and fail both clear when the next run starts.
- R11: Register writes, including a second go, have no effect while a run is in progress.
- R12: After reset, busy, done, fail and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index |
| cfg_wdata | input | REG_W | Register write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W+ECC_W | Write word, data and check lanes |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned, in request order |
| mem_rdata | input | DATA_W+ECC_W | Returned read word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| fail | output | 1 | Sticky compare failure |
| fail_addr | output | ADDR_W | First failing address |
| fail_mask | output | DATA_W+ECC_W | Mismatch mask of first failure |

## Verification
The bench builds the engine with a 6-bit address, so its model memory holds 64 words. This lets it fill windows that cross many addresses, and it keeps the 48 data bits plus 16 check bits at their defaults, so errors injected into the check lanes exercise the full-word compare. The 2-cycle pipelined read latency and the stalled grant pattern reach the case where read responses arrive while further reads are still being issued. A grant held high reaches the full-rate traversal.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_WRITE  = 2'd0;
  localparam logic [1:0] MODE_VERIFY = 2'd1;

  localparam logic [1:0] SRC_FIXED = 2'd0;
  localparam logic [1:0] SRC_LFSR  = 2'd1;

  // nibble for a pair index and member select (member 1 is the complement)
  function automatic logic [3:0] pair_nibble(input logic [1:0] pair, input logic second);
    logic [3:0] base;
    case (pair)
      2'd0:    base = 4'h0;
      2'd1:    base = 4'hA;
      2'd2:    base = 4'h3;
      default: base = 4'h6;
    endcase
    return second ? ~base : base;
  endfunction

endpackage

// File: rtl/mbist_cfg_regs.sv
module mbist_cfg_regs #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 64,
  parameter int REG_W  = 16,
  localparam int NDREG = WORD_W / REG_W,
  localparam int CFG_AW = $clog2(4 + NDREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [1:0]        mode_o,
  output logic [1:0]        src_o,
  output logic [2:0]        fix_code_o,
  output logic              shift_en_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o,
  output logic [REG_W-1:0]  seed_o,
  output logic [WORD_W-1:0] bank_o,
  output logic              go_o
);

  logic       go_q, go_d;
  logic       wr_ok;
  logic [7:0] ctrl_q;
  logic       ctrl_en, lo_en, hi_en, seed_en;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [REG_W-1:0]  seed_q;

  // writes are accepted only when idle and no start is pending
  always_comb begin
    wr_ok   = cfg_we && !busy_i && !go_q;
    ctrl_en = wr_ok && (cfg_addr == CFG_AW'(0));
    lo_en   = wr_ok && (cfg_addr == CFG_AW'(1));
    hi_en   = wr_ok && (cfg_addr == CFG_AW'(2));
    seed_en = wr_ok && (cfg_addr == CFG_AW'(3));
    go_d    = ctrl_en && cfg_wdata[REG_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      seed_q <= '0;
    end else begin
      go_q <= go_d;
      if (ctrl_en) ctrl_q <= cfg_wdata[7:0];
      if (lo_en)   lo_q   <= cfg_wdata[ADDR_W-1:0];
      if (hi_en)   hi_q   <= cfg_wdata[ADDR_W-1:0];
      if (seed_en) seed_q <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NDREG; i++) begin : g_bank
    logic [REG_W-1:0] dreg_q;
    logic             dreg_en;
    assign dreg_en = wr_ok && (cfg_addr == CFG_AW'(4 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dreg_q <= '0;
      else if (dreg_en) dreg_q <= cfg_wdata;
    end
    assign bank_o[i*REG_W +: REG_W] = dreg_q;
  end

  assign mode_o     = ctrl_q[1:0];
  assign src_o      = ctrl_q[3:2];
  assign fix_code_o = ctrl_q[6:4];
  assign shift_en_o = ctrl_q[7];
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign seed_o     = seed_q;
  assign go_o       = go_q;

  // a start request never coexists with an active run
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !busy_i);  // R11

endmodule

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen
  import mbist_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int REG_W  = 16,
  localparam int NDREG = WORD_W / REG_W,
  localparam int NNIB  = WORD_W / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [1:0]        src_i,
  input  logic [2:0]        fix_code_i,
  input  logic              shift_en_i,
  input  logic [REG_W-1:0]  seed_i,
  input  logic [WORD_W-1:0] bank_i,
  output logic [WORD_W-1:0] pat_o
);

  logic              tog_q, tog_d;
  logic [WORD_W-1:0] lfsr_q, lfsr_d;
  logic [WORD_W-1:0] work_q, work_d;
  logic              fb;

  always_comb begin
    fb     = lfsr_q[WORD_W-1] ^ lfsr_q[WORD_W-2] ^ lfsr_q[WORD_W-4] ^ lfsr_q[WORD_W-5];
    tog_d  = tog_q;
    lfsr_d = lfsr_q;
    work_d = work_q;
    if (load_i) begin
      tog_d  = 1'b0;
      lfsr_d = {NDREG{seed_i}};
      work_d = bank_i;
    end else if (adv_i) begin
      tog_d  = ~tog_q;
      lfsr_d = {lfsr_q[WORD_W-2:0], fb};
      if (shift_en_i) work_d = {work_q[WORD_W-2:0], work_q[WORD_W-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      lfsr_q <= '0;
      work_q <= '0;
    end else if (load_i || adv_i) begin
      tog_q  <= tog_d;
      lfsr_q <= lfsr_d;
      work_q <= work_d;
    end
  end

  always_comb begin
    case (src_i)
      SRC_FIXED: pat_o = {NNIB{pair_nibble(fix_code_i[2:1], fix_code_i[0] ^ tog_q)}};
      SRC_LFSR:  pat_o = lfsr_q;
      default:   pat_o = work_q;
    endcase
  end

  AST_FIX_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_FIXED && adv_i && !load_i) |=> pat_o == ~$past(pat_o));  // R2

  AST_BANK_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[1] && shift_en_i && adv_i && !load_i)
      |=> pat_o == {$past(pat_o[WORD_W-2:0]), $past(pat_o[WORD_W-1])});  // R5

  AST_LFSR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == SRC_LFSR && adv_i && !load_i)
      |=> pat_o[WORD_W-1:1] == $past(pat_o[WORD_W-2:0]));  // R3

endmodule

// File: rtl/mbist_sequencer.sv
module mbist_sequencer
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              gen_load_o,
  output logic              gen_adv_o,
  output logic              chk_en_o,
  output logic              chk_clr_o,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] rsp_q, rsp_d;
  logic              iss_q, iss_d;
  logic              done_q, done_d;

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    rsp_d      = rsp_q;
    iss_d      = iss_q;
    done_d     = done_q;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    gen_load_o = 1'b0;
    gen_adv_o  = 1'b0;
    chk_en_o   = 1'b0;
    chk_clr_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          chk_clr_o  = 1'b1;
          gen_load_o = 1'b1;
          done_d     = 1'b0;
          cur_d      = lo_i;
          rsp_d      = lo_i;
          if (mode_i == MODE_VERIFY) begin
            state_d = ST_RD;
            iss_d   = 1'b1;
          end else begin
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_gnt) begin
          if (cur_q == hi_i) begin
            if (mode_i == MODE_WRITE) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d    = ST_RD;
              cur_d      = lo_i;
              iss_d      = 1'b1;
              gen_load_o = 1'b1;
            end
          end else begin
            cur_d     = cur_q + 1'b1;
            gen_adv_o = 1'b1;
          end
        end
      end
      ST_RD: begin
        mem_req = iss_q;
        if (iss_q && mem_gnt) begin
          if (cur_q == hi_i) iss_d = 1'b0;
          else               cur_d = cur_q + 1'b1;
        end
        if (mem_rvalid) begin
          chk_en_o  = 1'b1;
          gen_adv_o = 1'b1;
          if (rsp_q == hi_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            rsp_d = rsp_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      rsp_q   <= '0;
      iss_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      rsp_q   <= rsp_d;
      iss_q   <= iss_d;
      done_q  <= done_d;
    end
  end

  assign mem_addr   = cur_q;
  assign chk_addr_o = rsp_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));  // R1

  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && lo_i <= hi_i) |-> (mem_addr >= lo_i && mem_addr <= hi_i));  // R1

  AST_NO_WRITE_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_i == MODE_VERIFY) |-> !(mem_req && mem_we));  // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);  // R10

endmodule

// File: rtl/mbist_checker.sv
module mbist_checker #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              chk_en_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0] expect_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [WORD_W-1:0] fail_mask_o
);

  logic [WORD_W-1:0] diff;
  logic              hit, first;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] mask_q, mask_d;

  always_comb begin
    diff   = rdata_i ^ expect_i;
    hit    = chk_en_i && (|diff);
    first  = hit && !fail_q;
    fail_d = fail_q;
    addr_d = addr_q;
    mask_d = mask_q;
    if (clr_i) begin
      fail_d = 1'b0;
      addr_d = '0;
      mask_d = '0;
    end else if (first) begin
      fail_d = 1'b1;
      addr_d = chk_addr_i;
      mask_d = diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else if (clr_i || first) begin
      fail_q <= fail_d;
      addr_q <= addr_d;
      mask_q <= mask_d;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = addr_q;
  assign fail_mask_o = mask_q;

  AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && rdata_i != expect_i && !clr_i) |=> fail_o);  // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> fail_o);  // R8

  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> $stable(fail_addr_o) && $stable(fail_mask_o));  // R8

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 48,
  parameter int ECC_W  = 16,
  parameter int REG_W  = 16,
  localparam int WORD_W = DATA_W + ECC_W,
  localparam int NDREG  = WORD_W / REG_W,
  localparam int CFG_AW = $clog2(4 + NDREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [WORD_W-1:0] fail_mask
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [1:0]        mode, src;
  logic [2:0]        fix_code;
  logic              shift_en, go;
  logic [ADDR_W-1:0] lo, hi, chk_addr;
  logic [REG_W-1:0]  seed;
  logic [WORD_W-1:0] bank, pat;
  logic              gen_load, gen_adv, chk_en, chk_clr;

  mbist_cfg_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .busy_i(busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_o(mode), .src_o(src), .fix_code_o(fix_code), .shift_en_o(shift_en),
    .lo_o(lo), .hi_o(hi), .seed_o(seed), .bank_o(bank), .go_o(go)
  );

  mbist_pattern_gen #(.WORD_W(WORD_W), .REG_W(REG_W)) u_gen (
    .clk(clk), .rst_n(rst_sync_q), .load_i(gen_load), .adv_i(gen_adv),
    .src_i(src), .fix_code_i(fix_code), .shift_en_i(shift_en),
    .seed_i(seed), .bank_i(bank), .pat_o(pat)
  );

  mbist_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .go_i(go), .mode_i(mode),
    .lo_i(lo), .hi_i(hi), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .gen_load_o(gen_load), .gen_adv_o(gen_adv), .chk_en_o(chk_en),
    .chk_clr_o(chk_clr), .chk_addr_o(chk_addr), .busy_o(busy), .done_o(done)
  );

  mbist_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_sync_q), .clr_i(chk_clr), .chk_en_i(chk_en),
    .chk_addr_i(chk_addr), .rdata_i(mem_rdata), .expect_i(pat),
    .fail_o(fail), .fail_addr_o(fail_addr), .fail_mask_o(fail_mask)
  );

  assign mem_wdata = pat;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> !mem_req && !busy && !done && !fail);  // R12

endmodule

// File: tb/sim_mbist_engine.sv
module sim_mbist_engine;

  localparam int AW = 6;
  localparam int W  = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic          mem_gnt = 1'b1;
  logic          mem_rvalid = 1'b0;
  logic [W-1:0]  mem_rdata = '0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [W-1:0]  fail_mask;

  always #4 clk = ~clk;  // 125 MHz

  mbist_engine #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr), .fail_mask(fail_mask)
  );

  // memory model: two-cycle pipelined reads
  logic [W-1:0] mem [0:63];
  logic         p0_v = 1'b0;
  logic [W-1:0] p0_d = '0;
  int           wr_cnt = 0, rd_cnt = 0, cyc = 0;
  int           stall = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    p0_v <= mem_req && mem_gnt && !mem_we;
    p0_d <= mem[mem_addr];
    if (mem_req && mem_gnt && !mem_we) rd_cnt <= rd_cnt + 1;
    mem_rvalid <= p0_v;
    mem_rdata  <= p0_d;
  end

  always @(negedge clk) mem_gnt = (stall == 0) ? 1'b1 : ((cyc % 3) == 0);

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, n_chk + 1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  function automatic logic [W-1:0] exp_word(input int src, input int code, input int k,
                                             input logic [15:0] seed, input logic [W-1:0] bank, input bit sh);
    logic [W-1:0] s;
    logic [3:0]   nb;
    bit           m;
    if (src == 0) begin
      m = code[0] ^ k[0];
      case (code >> 1)
        0:       nb = m ? 4'hF : 4'h0;
        1:       nb = m ? 4'h5 : 4'hA;
        2:       nb = m ? 4'hC : 4'h3;
        default: nb = m ? 4'h9 : 4'h6;
      endcase
      return {16{nb}};
    end else if (src == 1) begin
      s = {4{seed}};
      for (int i = 0; i < k; i++) s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      return s;
    end else begin
      s = bank;
      if (sh) for (int i = 0; i < k; i++) s = {s[62:0], s[63]};
      return s;
    end
  endfunction

  task automatic cfg_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_bank(input logic [W-1:0] b);
    for (int i = 0; i < 4; i++) cfg_wr(4 + i, b[i*16 +: 16]);
  endtask

  task automatic start(input int mode, input int src, input int code, input bit sh,
                       input int lo, input int hi, input logic [15:0] seed);
    cfg_wr(1, 16'(lo));
    cfg_wr(2, 16'(hi));
    cfg_wr(3, seed);
    cfg_wr(0, {1'b1, 7'b0, sh, 3'(code), 2'(src), 2'(mode)});
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_fill(input string req, input int src, input int code, input bit sh,
                            input int lo, input int hi, input logic [15:0] seed, input logic [W-1:0] bank);
    int bad = -1;
    for (int a = lo; a <= hi; a++)
      if (bad < 0 && mem[a] !== exp_word(src, code, a - lo, seed, bank, sh)) bad = a;
    if (bad < 0) check(1'b1, req, '0, '0);
    else check(1'b0, req, mem[bad], exp_word(src, code, bad - lo, seed, bank, sh));
  endtask

  task automatic preload(input int src, input int code, input int lo, input int hi);
    for (int a = lo; a <= hi; a++) mem[a] = exp_word(src, code, a - lo, 16'h0, '0, 1'b0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !fail && !mem_req, "R12 reset outputs", {60'b0, busy, done, fail, mem_req}, '0);
  endtask

  task automatic t_fixed();
    stall = 1;
    for (int c = 0; c < 8; c++) begin
      int r0 = rd_cnt;
      start(0, 0, c, 1'b0, 2 + c, 12 + c, 16'h0);
      wait_done();
      check_fill($sformatf("R2 fixed code %0d", c), 0, c, 1'b0, 2 + c, 12 + c, 16'h0, '0);
      if (c == 0) check(rd_cnt == r0, "R9 write-only issues no reads", W'(rd_cnt - r0), '0);
    end
    stall = 0;
  endtask

  task automatic t_rate();
    int n = 0;
    stall = 0;
    start(0, 0, 2, 1'b0, 0, 15, 16'h0);
    while (!(done && n > 2) && n < 200) begin @(negedge clk); n++; end
    check(n <= 20, "R1 full-rate traversal of 16 words", W'(n), W'(20));
    check_fill("R1 ascending fill", 0, 2, 1'b0, 0, 15, 16'h0, '0);
  endtask

  task automatic t_lfsr();
    stall = 1;
    start(2, 1, 0, 1'b0, 10, 40, 16'hACE1);
    wait_done();
    check_fill("R3 lfsr fill", 1, 0, 1'b0, 10, 40, 16'hACE1, '0);
    check(!fail, "R7 write-then-verify passes", W'(fail), '0);
    stall = 0;
  endtask

  task automatic t_bank();
    logic [W-1:0] b = 64'h0123_4567_89AB_CDEF;
    set_bank(b);
    start(0, 2, 0, 1'b0, 3, 9, 16'h0);
    wait_done();
    check_fill("R4 bank word order", 2, 0, 1'b0, 3, 9, 16'h0, b);
    stall = 1;
    start(2, 3, 0, 1'b1, 20, 60, 16'h0);
    wait_done();
    check_fill("R5 rotate per word", 2, 0, 1'b1, 20, 60, 16'h0, b);
    check(!fail, "R5 rotated verify passes", W'(fail), '0);
    stall = 0;
  endtask

  task automatic t_zero();
    for (int a = 0; a < 64; a++) mem[a] = '1;
    set_bank('0);
    start(2, 2, 0, 1'b1, 0, 63, 16'h0);
    wait_done();
    check_fill("R6 all-zero fill", 2, 0, 1'b0, 0, 63, 16'h0, '0);
    check(!fail && done, "R6 zero fill verifies", W'({fail, done}), W'(1));
  endtask

  task automatic t_verify();
    int w0;
    preload(0, 4, 16, 30);
    mem[20] = mem[20] ^ (64'h1 << 63);
    mem[25] = mem[25] ^ 64'h1;
    w0 = wr_cnt;
    stall = 1;
    start(1, 0, 4, 1'b0, 16, 30, 16'h0);
    wait_done();
    check(fail, "R7 check-lane error detected", W'(fail), W'(1));
    check(fail_addr == 6'd20, "R8 first failing address", W'(fail_addr), W'(20));
    check(fail_mask == (64'h1 << 63), "R8 first mismatch mask", fail_mask, 64'h1 << 63);
    check(wr_cnt == w0, "R9 verify-only issues no writes", W'(wr_cnt - w0), '0);
    // next run clears fail
    preload(0, 4, 16, 30);
    start(1, 0, 4, 1'b0, 16, 30, 16'h0);
    repeat (3) @(negedge clk);
    check(!fail && !done && busy, "R10 start clears done and fail", W'({fail, done, busy}), W'(1));
    wait_done();
    check(!fail && done && !busy, "R10 clean verify ends done", W'({fail, done, busy}), W'(2));
    stall = 0;
  endtask

  task automatic t_ignore();
    stall = 1;
    start(0, 1, 0, 1'b0, 0, 30, 16'h1234);
    repeat (10) @(negedge clk);
    cfg_wr(3, 16'hFFFF);
    cfg_wr(2, 16'd5);
    cfg_wr(0, 16'h8006);
    wait_done();
    check_fill("R11 writes ignored while busy", 1, 0, 1'b0, 0, 30, 16'h1234, '0);
    start(0, 1, 0, 1'b0, 31, 33, 16'h1234);
    wait_done();
    check_fill("R11 seed kept after busy write", 1, 0, 1'b0, 31, 33, 16'h1234, '0);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fixed();
    t_rate();
    t_lfsr();
    t_bank();
    t_zero();
    t_verify();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule